// File: doc/BRIEF.md
# Paged 24-Bit Dual Data Pointer

This block holds the address pointers of an 8051-class core whose external data space has grown to 16 MB. Each pointer is a 24-bit value made of a page byte (bits 23:16), a high byte (bits 15:8) and a low byte (bits 7:0). Two such pointers exist, and a registered select bit decides which one is active. Only the active pointer is read or written, loaded, incremented, and driven onto the address output.

Legacy code treats the pointer as a 16-bit register. It loads the high and low halves in one step, and that load leaves the page byte alone. The increment strobe is different: it counts through all 24 bits, so a carry out of the high byte moves into the page byte. Software can also read and write each of the three bytes on its own through a small byte-register port.

Top module: `paged_dptr`

## Requirements
- R1: After reset, both pointers are 0x000000, pointer 0 is selected, and `addr_out` reads 0x000000.
- R2: `addr_out` always shows the active pointer, laid out as {page, high, low}.
- R3: When `inc` is high, the active pointer gains one on the next clock edge. A carry out of bit 15 moves into the page byte, so 0x00FFFF becomes 0x010000.
- R4: Incrementing 0xFFFFFF gives 0x000000.
- R5: `ld_en` writes `ld_data` into the high and low bytes of the active pointer. The page byte does not change.
- R6: On `byte_we`, `byte_wdata` is written to the byte of the active pointer that `byte_addr` names: 0 is low, 1 is high, 2 is page.
- R7: `byte_rdata` shows the byte of the active pointer that `byte_addr` names, with no clock delay.
- R8: Byte address 3 reads as 0x00. A write to byte address 3 changes no pointer byte.
- R9: The inactive pointer keeps its value. Loads, byte writes and increments act only on the active pointer.
- R10: `sel_we` loads `sel_d` into the select bit at the clock edge. Any load, write or increment in that same cycle still acts on the pointer that was selected before the edge.
- R11: If several updates arrive in the same cycle, only one takes effect. A 16-bit load wins over a byte write, and a byte write wins over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Select-bit write strobe |
| sel_d | input | 1 | New select value (0 or 1) |
| byte_we | input | 1 | Byte write strobe |
| byte_addr | input | 2 | Byte select: 0 low, 1 high, 2 page, 3 unused |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Selected byte of the active pointer |
| ld_en | input | 1 | 16-bit load strobe |
| ld_data | input | 16 | Value for the high and low bytes |
| inc | input | 1 | Increment strobe |
| addr_out | output | 24 | Active pointer as {page, high, low} |

## Verification
Two pairs of functions can land in the same clock edge. The first is an increment together with a load or a byte write. The second is a select change together with an update to the pointer. The bench drives these pairs in one cycle: an increment alongside a high-byte write, a load alongside an increment, and a select toggle alongside an increment. A cycle-accurate reference model predicts `addr_out` after each edge, so the bench can confirm which update won, which pointer it landed on, and that the other pointer did not move.

// File: rtl/paged_dptr.sv
module paged_dptr #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic            sel_d,
  input  logic            byte_we,
  input  logic [1:0]      byte_addr,
  input  logic [BW-1:0]   byte_wdata,
  output logic [BW-1:0]   byte_rdata,
  input  logic            ld_en,
  input  logic [2*BW-1:0] ld_data,
  input  logic            inc,
  output logic [3*BW-1:0] addr_out
);
  localparam int AW = 3 * BW;
  localparam int LW = 2 * BW;

  logic [AW-1:0] ptr [2];
  logic          sel_q;

  assign addr_out = ptr[sel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr[0] <= '0;
      ptr[1] <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (sel_we) sel_q <= sel_d;
      if (ld_en)
        ptr[sel_q][LW-1:0] <= ld_data;
      else if (byte_we) begin
        case (byte_addr)
          2'd0:    ptr[sel_q][BW-1:0]    <= byte_wdata;
          2'd1:    ptr[sel_q][LW-1:BW]   <= byte_wdata;
          2'd2:    ptr[sel_q][AW-1:LW]   <= byte_wdata;
          default: ;
        endcase
      end else if (inc)
        ptr[sel_q] <= addr_out + AW'(1);
    end
  end

  always_comb begin
    case (byte_addr)
      2'd0:    byte_rdata = addr_out[BW-1:0];
      2'd1:    byte_rdata = addr_out[LW-1:BW];
      2'd2:    byte_rdata = addr_out[AW-1:LW];
      default: byte_rdata = '0;
    endcase
  end

  // R3 / R4: lone increment, select unchanged
  a_r3_inc_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_en && !byte_we && !sel_we) |=> addr_out == AW'($past(addr_out) + AW'(1)));

  // R5: page byte survives a 16-bit load
  a_r5_load_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !sel_we) |=> (addr_out[AW-1:LW] == $past(addr_out[AW-1:LW]))
                           && (addr_out[LW-1:0] == $past(ld_data)));

  // R8: unused byte address reads zero
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_addr == 2'd3) |-> byte_rdata == '0);

  // R9: inactive pointer holds
  a_r9_hold_p1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 1'b0) |=> $stable(ptr[1]));
  a_r9_hold_p0: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 1'b1) |=> $stable(ptr[0]));

  // R10: select write lands on the next edge
  a_r10_sel_update: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_q == $past(sel_d));
endmodule

// File: tb/paged_dptr_tb.sv
module paged_dptr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 0, sel_d = 0, byte_we = 0, ld_en = 0, inc = 0;
  logic [1:0]  byte_addr = 0;
  logic [7:0]  byte_wdata = 0, byte_rdata;
  logic [15:0] ld_data = 0;
  logic [23:0] addr_out;

  int checks = 0, failures = 0;
  logic [23:0] mp [2];
  logic        msel;
  logic [23:0] exp_q [$];
  string       tag_q [$];
  bit          done = 0;

  always #4 clk = ~clk;

  paged_dptr u_dut (.clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_d(sel_d),
    .byte_we(byte_we), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
    .byte_rdata(byte_rdata), .ld_en(ld_en), .ld_data(ld_data), .inc(inc),
    .addr_out(addr_out));

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected addr_out pushed to the scoreboard
  task automatic op(input string tag, input bit l, input logic [15:0] lv,
                    input bit w, input logic [1:0] wa, input logic [7:0] wd,
                    input bit i, input bit sw, input bit sd);
    @(negedge clk);
    ld_en = l; ld_data = lv; byte_we = w; byte_addr = wa; byte_wdata = wd;
    inc = i; sel_we = sw; sel_d = sd;
    @(posedge clk);
    #1;
    ld_en = 0; byte_we = 0; inc = 0; sel_we = 0;
    if (l) mp[msel][15:0] = lv;
    else if (w) begin
      case (wa)
        2'd0: mp[msel][7:0] = wd;
        2'd1: mp[msel][15:8] = wd;
        2'd2: mp[msel][23:16] = wd;
        default: ;
      endcase
    end else if (i) mp[msel] = mp[msel] + 24'd1;
    if (sw) msel = sd;
    exp_q.push_back(mp[msel]);
    tag_q.push_back(tag);
  endtask

  // monitor: pops expected values and compares away from the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) check(tag_q.pop_front(), addr_out, exp_q.pop_front());
  end

  task automatic rd(input string tag, input logic [1:0] a);
    logic [7:0] e;
    @(negedge clk);
    #1;
    byte_addr = a;
    #1;
    case (a)
      2'd0: e = mp[msel][7:0];
      2'd1: e = mp[msel][15:8];
      2'd2: e = mp[msel][23:16];
      default: e = 8'h00;
    endcase
    check(tag, {16'h0, byte_rdata}, {16'h0, e});
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
    $finish;
  end

  initial begin
    mp[0] = 0; mp[1] = 0; msel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset addr", addr_out, 24'h0);
    op("R1 reset p1 zero", 0, 0, 0, 0, 0, 0, 1, 1);
    op("R10 back to p0", 0, 0, 0, 0, 0, 0, 1, 0);
    op("R5 load", 1, 16'hFFFE, 0, 0, 0, 0, 0, 0);
    op("R6 page write", 0, 0, 1, 2'd2, 8'h12, 0, 0, 0);
    op("R2 R3 inc", 0, 0, 0, 0, 0, 1, 0, 0);
    op("R3 carry into page", 0, 0, 0, 0, 0, 1, 0, 0);
    op("R5 load keeps page", 1, 16'hABCD, 0, 0, 0, 0, 0, 0);
    rd("R7 read low", 2'd0);
    rd("R7 read high", 2'd1);
    rd("R7 read page", 2'd2);
    op("R8 write to addr3 ignored", 0, 0, 1, 2'd3, 8'h77, 0, 0, 0);
    rd("R8 read addr3 zero", 2'd3);
    op("R6 low write", 0, 0, 1, 2'd0, 8'h5A, 0, 0, 0);
    op("R6 high write", 0, 0, 1, 2'd1, 8'hC3, 0, 0, 0);
    op("R11 write beats inc", 0, 0, 1, 2'd1, 8'hFF, 1, 0, 0);
    op("R11 load beats write and inc", 1, 16'h0102, 1, 2'd2, 8'h99, 1, 0, 0);
    op("R10 inc on old ptr while switching", 0, 0, 0, 0, 0, 1, 1, 1);
    op("R9 p1 untouched by p0 inc", 0, 0, 0, 0, 0, 0, 0, 0);
    op("R4 set p1 page", 0, 0, 1, 2'd2, 8'hFF, 0, 0, 0);
    op("R4 set p1 low16", 1, 16'hFFFF, 0, 0, 0, 0, 0, 0);
    op("R4 wrap", 0, 0, 0, 0, 0, 1, 0, 0);
    op("R9 p0 held while p1 used", 0, 0, 0, 0, 0, 0, 1, 0);
    rd("R7 read p0 page", 2'd2);
    op("R10 load on p0 while switching", 1, 16'h4444, 0, 0, 0, 0, 1, 1);
    op("R9 p1 still wrapped", 0, 0, 0, 0, 0, 0, 0, 0);
    op("R9 p0 got load", 0, 0, 0, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule